// File: doc/BRIEF.md
# Dual-Channel Sample Aligner and Frame Formatter

This block sits between two charge digitizer channels and a serializer. Every clock each channel delivers one sample: a floating-point style value (2-bit exponent, 5-bit mantissa) tagged with a 2-bit capacitor ID. That ID names the time slice of the digitizer's four-step pipeline. A per-channel control bit adds zero or one clock of delay so that both channels line up in time. The aligned pair is then packed into one output word per clock.

An orbit marker input starts each orbit. In the cycle that follows the marker, the block sends an orbit message carrying the bunch count that was present at the marker. In the same cycle it pulses a reset to both digitizers, so that their capacitor IDs restart at 0. Data words follow the orbit message. In test mode a supplied pattern word replaces the data words.

The block also watches the aligned capacitor IDs. Both channels must carry the same ID. After each orbit start the ID must run 0,1,2,3,0 and so on. Any breach sets a sticky error flag.

Top module: `dual_chan_framer`

## Requirements
- R1: While reset is asserted, `frameWord` is 0 and both `digReset` and `capErr` are 0.
- R2: If `orbitMark` is high in a cycle, the next `frameWord` is the orbit message `{2'b10, 4'hA, bunchCnt}`. Bits 17:16 hold the type code, bits 15:12 hold the header code, and bits 11:0 hold the `bunchCnt` value from that cycle.
- R3: `digReset` is high in exactly those cycles that follow a cycle with `orbitMark` high.
- R4: With an alignment bit of 0, a channel's fields in the data word come from the sample presented in the same cycle. The data word is `{2'b01, cap0, em1, em0}`. Here `em` is the 7-bit exponent/mantissa, `em0` sits at bits 6:0, `em1` at bits 13:7, and `cap0` (the aligned channel-0 capacitor ID) at bits 15:14. A sample input is laid out as `{cap[8:7], exp[6:5], mant[4:0]}`.
- R5: With a channel's alignment bit at 1 (`alignSel[0]` for channel 0, `alignSel[1]` for channel 1), that channel's fields come from the sample presented one clock earlier.
- R6: With `testMode` high and no orbit marker, the next `frameWord` is `{2'b11, testPattern}`. When both are high, the orbit message takes priority.
- R7: After the first orbit marker, `capErr` is set when the two aligned capacitor IDs differ in any cycle without an orbit marker.
- R8: After an orbit marker, the aligned capacitor ID is expected to be 0 and then to increase by 1 modulo 4 every cycle. Any other value sets `capErr`.
- R9: Once set, `capErr` stays at 1 until reset, including across later orbit markers.
- R10: Before the first orbit marker following reset, no capacitor ID value sets `capErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Active-low synchronous reset |
| orbitMark | input | 1 | Orbit start marker, one cycle |
| testMode | input | 1 | Send test pattern instead of data |
| alignSel | input | 2 | Per-channel one-clock delay enable |
| ch0Sample | input | 9 | Channel 0 sample {cap, exp, mant} |
| ch1Sample | input | 9 | Channel 1 sample {cap, exp, mant} |
| bunchCnt | input | 12 | Bunch count to embed in orbit message |
| testPattern | input | 16 | Test pattern payload |
| frameWord | output | 18 | Output word toward the serializer |
| digReset | output | 1 | Reset pulse to both digitizers |
| capErr | output | 1 | Sticky capacitor ID error |

## Verification
On every cycle the assertions confirm four things: the orbit message content and its one-cycle latency, the reset pulse that follows each marker, the test word content, and that the error flag stays stable when checking is disabled and never clears once set. Three behaviours appear only in the bench's scenarios: the one-clock alignment under all four delay combinations, the exact packing of the aligned samples, and the detection of channel mismatches and rotation skips (including a wrong restart value after an orbit). The bench drives each channel early by its configured delay so that the aligned stream follows a known rotation, and it predicts every word arithmetically.

// File: rtl/framer_pkg.sv
package framer_pkg;
  typedef struct packed {
    logic orbit;
    logic test;
    logic check;
  } strobes_t;

  localparam logic [1:0] TYPE_DATA  = 2'b01;
  localparam logic [1:0] TYPE_ORBIT = 2'b10;
  localparam logic [1:0] TYPE_TEST  = 2'b11;
endpackage

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     orbitMark,
  input  logic     testMode,
  output strobes_t strobes,
  output logic     digReset
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      digReset <= 1'b0;
    end else begin
      if (orbitMark) armed <= 1'b1;
      digReset <= orbitMark;
    end
  end

  always_comb begin
    strobes.orbit = orbitMark;
    strobes.test  = testMode & ~orbitMark;
    strobes.check = armed & ~orbitMark;
  end

  // R3: a reset pulse follows every orbit marker
  p_reset_after_orbit_r3: assert property (@(posedge clk) disable iff (!rstN)
    orbitMark |=> digReset);
  // R3: no reset pulse without a marker
  p_no_stray_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
    !orbitMark |=> !digReset);
endmodule

// File: rtl/framer_dp.sv
module framer_dp
  import framer_pkg::*;
#(
  parameter int EXP_W    = 2,
  parameter int MANT_W   = 5,
  parameter int CAP_W    = 2,
  parameter int BC_W     = 12,
  parameter int HDR_CODE = 10,
  localparam int SAMP_W  = EXP_W + MANT_W,
  localparam int IN_W    = CAP_W + SAMP_W,
  localparam int WORD_W  = 2 + CAP_W + 2 * SAMP_W,
  localparam int PAY_W   = WORD_W - 2,
  localparam int HDR_W   = PAY_W - BC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [1:0]        alignSel,
  input  logic [IN_W-1:0]   ch0Sample,
  input  logic [IN_W-1:0]   ch1Sample,
  input  logic [BC_W-1:0]   bunchCnt,
  input  logic [PAY_W-1:0]  testPattern,
  output logic [WORD_W-1:0] frameWord,
  output logic              capErr
);
  localparam int NCH = 2;

  logic [IN_W-1:0]  rawS   [NCH];
  logic [IN_W-1:0]  dlyQ   [NCH];
  logic [IN_W-1:0]  alignS [NCH];
  logic [CAP_W-1:0] capA   [NCH];
  logic [CAP_W-1:0] expCap;
  logic             capBad;

  assign rawS[0] = ch0Sample;
  assign rawS[1] = ch1Sample;

  for (genvar k = 0; k < NCH; k++) begin : g_align
    always_ff @(posedge clk) begin
      if (!rstN) dlyQ[k] <= '0;
      else       dlyQ[k] <= rawS[k];
    end
    assign alignS[k] = alignSel[k] ? dlyQ[k] : rawS[k];
    assign capA[k]   = alignS[k][IN_W-1 -: CAP_W];
  end

  assign capBad = (capA[0] != capA[1]) || (capA[0] != expCap);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expCap <= '0;
      capErr <= 1'b0;
    end else begin
      expCap <= strobes.orbit ? '0 : CAP_W'(capA[0] + 1'b1);
      if (strobes.check && capBad) capErr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              frameWord <= '0;
    else if (strobes.orbit) frameWord <= {TYPE_ORBIT, HDR_W'(HDR_CODE), bunchCnt};
    else if (strobes.test)  frameWord <= {TYPE_TEST, testPattern};
    else                    frameWord <= {TYPE_DATA, capA[0],
                                          alignS[1][SAMP_W-1:0], alignS[0][SAMP_W-1:0]};
  end

  // R2: orbit message content one clock after the marker
  p_orbit_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.orbit |=> frameWord == {TYPE_ORBIT, HDR_W'(HDR_CODE), $past(bunchCnt)});
  // R6: test word carries the pattern
  p_test_word_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.test |=> frameWord == {TYPE_TEST, $past(testPattern)});
  // R9: error flag never clears
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    capErr |=> capErr);
  // R10: without checking the flag holds
  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.check |=> capErr == $past(capErr));
endmodule

// File: rtl/dual_chan_framer.sv
module dual_chan_framer
  import framer_pkg::*;
#(
  parameter int EXP_W    = 2,
  parameter int MANT_W   = 5,
  parameter int CAP_W    = 2,
  parameter int BC_W     = 12,
  parameter int HDR_CODE = 10
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 orbitMark,
  input  logic                                 testMode,
  input  logic [1:0]                           alignSel,
  input  logic [CAP_W+EXP_W+MANT_W-1:0]        ch0Sample,
  input  logic [CAP_W+EXP_W+MANT_W-1:0]        ch1Sample,
  input  logic [BC_W-1:0]                      bunchCnt,
  input  logic [CAP_W+2*(EXP_W+MANT_W)-1:0]    testPattern,
  output logic [CAP_W+2*(EXP_W+MANT_W)+1:0]    frameWord,
  output logic                                 digReset,
  output logic                                 capErr
);
  strobes_t strobes;

  framer_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .orbitMark (orbitMark),
    .testMode  (testMode),
    .strobes   (strobes),
    .digReset  (digReset)
  );

  framer_dp #(
    .EXP_W    (EXP_W),
    .MANT_W   (MANT_W),
    .CAP_W    (CAP_W),
    .BC_W     (BC_W),
    .HDR_CODE (HDR_CODE)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .alignSel    (alignSel),
    .ch0Sample   (ch0Sample),
    .ch1Sample   (ch1Sample),
    .bunchCnt    (bunchCnt),
    .testPattern (testPattern),
    .frameWord   (frameWord),
    .capErr      (capErr)
  );
endmodule

// File: tb/dual_chan_framer_tb_top.sv
module dual_chan_framer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        orbitMark = 1'b0;
  logic        testMode = 1'b0;
  logic [1:0]  alignSel = 2'b00;
  logic [8:0]  ch0Sample = '0;
  logic [8:0]  ch1Sample = '0;
  logic [11:0] bunchCnt = '0;
  logic [15:0] testPattern = '0;
  logic [17:0] frameWord;
  logic        digReset;
  logic        capErr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dual_chan_framer dut_i (
    .clk(clk), .rstN(rstN), .orbitMark(orbitMark), .testMode(testMode),
    .alignSel(alignSel), .ch0Sample(ch0Sample), .ch1Sample(ch1Sample),
    .bunchCnt(bunchCnt), .testPattern(testPattern), .frameWord(frameWord),
    .digReset(digReset), .capErr(capErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // sample with cap = (m-1) mod 4 and a channel-dependent value
  function automatic logic [8:0] gen(input int k, input int m, input int salt);
    logic [1:0] c;
    logic [6:0] em;
    c  = 2'((m + 3) & 3);
    em = 7'((m * 11 + k * 45 + salt) & 127);
    return {c, em};
  endfunction

  task automatic cyc(input logic om, input logic tm, input logic [8:0] s0,
                     input logic [8:0] s1, input logic [11:0] bc, input logic [15:0] tp);
    @(negedge clk);
    orbitMark = om; testMode = tm; ch0Sample = s0; ch1Sample = s1;
    bunchCnt = bc; testPattern = tp;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; orbitMark = 1'b0; testMode = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R1 frameWord", 32'(frameWord), 0);
      chk("R1 digReset", 32'(digReset), 0);
      chk("R1 capErr", 32'(capErr), 0);
    end
    @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [17:0] dataWord(input int j, input int salt);
    logic [8:0] a0, a1;
    a0 = gen(0, j, salt);
    a1 = gen(1, j, salt);
    return {2'b01, a0[8:7], a1[6:0], a0[6:0]};
  endfunction

  initial begin
    doReset();

    // unarmed: mismatching caps must not flag (R10), data packing (R4)
    alignSel = 2'b00;
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b0, {2'(i), 7'(i * 3)}, {2'(i + 2), 7'(i * 5 + 1)}, 12'h0, 16'h0);
      chk("R4 unarmed word", 32'(frameWord), 32'({2'b01, 2'(i), 7'(i * 5 + 1), 7'(i * 3)}));
      chk("R10 no check before orbit", 32'(capErr), 0);
    end

    // sweep all alignment settings
    for (int s = 0; s < 4; s++) begin
      int sel0, sel1, salt;
      logic [11:0] bc;
      logic [15:0] tp;
      sel0 = s & 1; sel1 = (s >> 1) & 1; salt = 17 * s + 3;
      bc = 12'(s * 700 + 123); tp = 16'(16'hC35A ^ (s * 16'h1111));
      alignSel = 2'(s);
      for (int j = 0; j <= 12; j++) begin
        logic om, tm;
        om = (j == 0);
        tm = (j == 6) || (j == 0 && s == 3);
        cyc(om, tm, gen(0, j + sel0, salt), gen(1, j + sel1, salt), bc, tp);
        if (j == 0) begin
          chk("R2/R6 orbit word", 32'(frameWord), 32'({2'b10, 4'hA, bc}));
          chk("R3 digReset high", 32'(digReset), 1);
        end else begin
          chk("R3 digReset low", 32'(digReset), 0);
          if (tm) chk("R6 test word", 32'(frameWord), 32'({2'b11, tp}));
          else if (s == 0) chk("R4 data word", 32'(frameWord), 32'(dataWord(j, salt)));
          else chk("R5 aligned word", 32'(frameWord), 32'(dataWord(j, salt)));
          chk("R8 valid rotation no error", 32'(capErr), 0);
        end
      end
    end

    // R7 mismatch, then R9 sticky
    alignSel = 2'b00;
    cyc(1'b1, 1'b0, gen(0, 0, 0), gen(1, 0, 0), 12'h5, 16'h0);
    for (int j = 1; j <= 5; j++) begin
      logic [8:0] s1;
      s1 = gen(1, j, 0);
      if (j == 3) s1[8:7] = s1[8:7] + 2'd1;
      cyc(1'b0, 1'b0, gen(0, j, 0), s1, 12'h5, 16'h0);
      if (j < 3) chk("R7 no error yet", 32'(capErr), 0);
      else if (j == 3) chk("R7 mismatch sets error", 32'(capErr), 1);
      else chk("R9 error stays", 32'(capErr), 1);
    end
    cyc(1'b1, 1'b0, gen(0, 0, 0), gen(1, 0, 0), 12'h6, 16'h0);
    chk("R9 error survives orbit", 32'(capErr), 1);
    doReset();

    // R8 skip in rotation
    cyc(1'b1, 1'b0, gen(0, 0, 9), gen(1, 0, 9), 12'h7, 16'h0);
    cyc(1'b0, 1'b0, gen(0, 1, 9), gen(1, 1, 9), 12'h7, 16'h0);
    chk("R8 first sample ok", 32'(capErr), 0);
    cyc(1'b0, 1'b0, gen(0, 3, 9), gen(1, 3, 9), 12'h7, 16'h0);
    chk("R8 skip sets error", 32'(capErr), 1);
    doReset();

    // R8 wrong restart value after orbit
    cyc(1'b1, 1'b0, gen(0, 0, 9), gen(1, 0, 9), 12'h8, 16'h0);
    cyc(1'b0, 1'b0, gen(0, 2, 9), gen(1, 2, 9), 12'h8, 16'h0);
    chk("R8 restart not zero sets error", 32'(capErr), 1);
    doReset();
    chk("R1 error cleared by reset", 32'(capErr), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule